// File: doc/BRIEF.md
# Finite Automaton Emptiness Checker

This block decides whether a small deterministic finite automaton over the alphabet {0, 1} accepts any word at all. A host loads the automaton into internal registers through a narrow write port: for every state, the state entered on input 0 and on input 1, plus one start-state index and a mask of accepting states. A single pulse on `start` then launches a breadth-first reachability search. The search begins at the start state and takes one step per clock. Each step adds the unvisited successors of the current frontier as the new frontier.

The search stops as soon as the frontier holds an accepting state, and then reports that the language is not empty. It also stops when the frontier runs dry, and then reports that the language is empty. An automaton with no accepting states is empty by this rule. A complement input, sampled with `start`, swaps accepting and non-accepting states for that search and leaves the start state as it is. This lets the same table answer whether the automaton rejects some word.

Top module: `dfa_empty_chk`

## Requirements
- R1: After reset `busy`, `done` and `empty` are 0, every state's two successors are the state itself, the start index is 0 and the accepting mask is all zero.
- R2: While `busy` is 0 and `start` is 0, a write with `wr_en`=1 stores `wr_data` by `wr_sel`: 2'b00 sets the input-0 successor of state `wr_addr` to `wr_data[IDX_W-1:0]`, 2'b01 sets the input-1 successor, 2'b10 sets the start index to `wr_data[IDX_W-1:0]`, 2'b11 sets the accepting mask to `wr_data` (bit i = state i). A write while `busy`=1, or in the same cycle as `start`, is dropped.
- R3: A `start` pulse while idle raises `busy` on the next edge and clears `done`. Let level 1 be the start state alone, and let level k+1 be the successors of level k that are in no earlier level. `done` rises and `busy` falls at edge n after the start edge. Here n is the first level that holds an accepting state, or else the first level that is empty.
- R4: When an accepting state is reachable from the start state, `empty` is 0 at the moment `done` rises.
- R5: When accepting states exist but none is reachable, `empty` is 1 with `done`.
- R6: An all-zero effective accepting mask always yields `empty`=1.
- R7: With `compl_mode`=1 at the start pulse, the effective accepting mask is the bitwise inverse of the stored mask. The start state and the table are unchanged.
- R8: `start` while `busy`=1 is ignored, and the running search keeps its timing. `done` and `empty` hold until the next accepted `start`.
- R9: A search occupies at most N_STATES+1 busy cycles, and the frontier never holds a state that was already visited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Write target: 00 input-0 successor, 01 input-1 successor, 10 start index, 11 accepting mask |
| wr_addr | input | IDX_W | State whose successor is written |
| wr_data | input | N_STATES | Write value (successor or start index in low IDX_W bits, or mask) |
| start | input | 1 | Launch a search (one-cycle pulse) |
| compl_mode | input | 1 | Search the complemented accepting set |
| busy | output | 1 | Search in progress; table writes are locked |
| done | output | 1 | Result valid, held until next start |
| empty | output | 1 | 1 when no word is accepted |

## Verification
The in-line assertions check on every cycle that the table stays frozen while a search runs or launches, and that the visited set only grows. They also check that no frontier repeats a visited state, that the iteration count stays within N_STATES+1, that `done` and `busy` never overlap, and that a zero effective mask ends empty. Only the bench scenarios can show the exact cycle in which `done` rises and the correctness of the verdict. They compare a behavioural level-by-level model on every clock, over directed chains, unreachable and start-state accepting cases, complement runs and random tables. Those tables include all-zero masks, dropped writes and ignored restarts.

// File: rtl/dfa_chk_pkg.sv
package dfa_chk_pkg;

   typedef enum logic [1:0] {
      SEL_NEXT0 = 2'b00,
      SEL_NEXT1 = 2'b01,
      SEL_START = 2'b10,
      SEL_FINAL = 2'b11
   } wr_sel_e;

endpackage

// File: rtl/dfa_table.sv
module dfa_table
   import dfa_chk_pkg::*;
#(
   parameter int N_STATES = 8,
   parameter int IDX_W    = $clog2(N_STATES)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [1:0]                       wr_sel,
   input  logic [IDX_W-1:0]                 wr_addr,
   input  logic [N_STATES-1:0]              wr_data,
   input  logic                             lock,
   output logic [N_STATES-1:0][IDX_W-1:0]   nxt0,
   output logic [N_STATES-1:0][IDX_W-1:0]   nxt1,
   output logic [IDX_W-1:0]                 start_idx,
   output logic [N_STATES-1:0]              final_mask
);

   wr_sel_e sel;
   logic    accept_wr;

   assign sel       = wr_sel_e'(wr_sel);
   assign accept_wr = wr_en && !lock;

   for (genvar s = 0; s < N_STATES; s++) begin : g_row
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            nxt0[s] <= IDX_W'(s);
            nxt1[s] <= IDX_W'(s);
         end else if (accept_wr && wr_addr == IDX_W'(s)) begin
            if (sel == SEL_NEXT0) nxt0[s] <= wr_data[IDX_W-1:0];
            if (sel == SEL_NEXT1) nxt1[s] <= wr_data[IDX_W-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_idx  <= '0;
         final_mask <= '0;
      end else if (accept_wr) begin
         if (sel == SEL_START) start_idx  <= wr_data[IDX_W-1:0];
         if (sel == SEL_FINAL) final_mask <= wr_data;
      end
   end

   AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> ($stable(nxt0) && $stable(nxt1) && $stable(start_idx) && $stable(final_mask))); // R2

endmodule

// File: rtl/dfa_succ.sv
module dfa_succ #(
   parameter int N_STATES  = 8,
   parameter int IDX_W     = $clog2(N_STATES),
   parameter int SUCC_IMPL = 0
) (
   input  logic [N_STATES-1:0]              frontier,
   input  logic [N_STATES-1:0][IDX_W-1:0]   nxt0,
   input  logic [N_STATES-1:0][IDX_W-1:0]   nxt1,
   output logic [N_STATES-1:0]              succ
);

   if (SUCC_IMPL == 0) begin : g_by_source
      logic [N_STATES-1:0] fan [N_STATES];
      for (genvar s = 0; s < N_STATES; s++) begin : g_src
         assign fan[s] = frontier[s]
                         ? ((N_STATES'(1) << nxt0[s]) | (N_STATES'(1) << nxt1[s]))
                         : '0;
      end
      always_comb begin
         succ = '0;
         for (int s = 0; s < N_STATES; s++) succ = succ | fan[s];
      end
   end else begin : g_by_target
      logic [N_STATES-1:0] hits [N_STATES];
      for (genvar t = 0; t < N_STATES; t++) begin : g_tgt
         for (genvar s = 0; s < N_STATES; s++) begin : g_src
            assign hits[t][s] = frontier[s] &&
                                (nxt0[s] == IDX_W'(t) || nxt1[s] == IDX_W'(t));
         end
         assign succ[t] = |hits[t];
      end
   end

endmodule

// File: rtl/dfa_search.sv
module dfa_search #(
   parameter int N_STATES = 8,
   parameter int IDX_W    = $clog2(N_STATES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  compl_mode,
   input  logic [IDX_W-1:0]      start_idx,
   input  logic [N_STATES-1:0]   final_mask,
   input  logic [N_STATES-1:0]   succ,
   output logic [N_STATES-1:0]   frontier,
   output logic                  busy,
   output logic                  done,
   output logic                  empty
);

   localparam int ITER_W = $clog2(N_STATES + 2);

   logic [N_STATES-1:0] visited_q;
   logic [N_STATES-1:0] accept_q;
   logic [ITER_W-1:0]   iter_q;
   logic                launch;
   logic                hit_final;
   logic                dry;

   assign launch    = start && !busy;
   assign hit_final = |(frontier & accept_q);
   assign dry       = (frontier == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         done      <= 1'b0;
         empty     <= 1'b0;
         visited_q <= '0;
         frontier  <= '0;
         accept_q  <= '0;
         iter_q    <= '0;
      end else if (launch) begin
         busy      <= 1'b1;
         done      <= 1'b0;
         empty     <= 1'b0;
         visited_q <= N_STATES'(1) << start_idx;
         frontier  <= N_STATES'(1) << start_idx;
         accept_q  <= compl_mode ? ~final_mask : final_mask;
         iter_q    <= '0;
      end else if (busy) begin
         iter_q <= iter_q + 1'b1;
         if (hit_final) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            empty <= 1'b0;
         end else if (dry) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            empty <= 1'b1;
         end else begin
            frontier  <= succ & ~visited_q;
            visited_q <= visited_q | succ;
         end
      end
   end

   AST_VISITED_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ((visited_q & $past(visited_q)) == $past(visited_q))); // R9
   AST_FRONTIER_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ((frontier & $past(visited_q)) == '0)); // R9
   AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (32'(iter_q) <= N_STATES)); // R9
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R3
   AST_ZERO_MASK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && accept_q == '0) |-> empty); // R6
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(empty))); // R8

endmodule

// File: rtl/dfa_empty_chk.sv
module dfa_empty_chk #(
   parameter int N_STATES  = 8,
   parameter int IDX_W     = $clog2(N_STATES),
   parameter int SUCC_IMPL = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [1:0]            wr_sel,
   input  logic [IDX_W-1:0]      wr_addr,
   input  logic [N_STATES-1:0]   wr_data,
   input  logic                  start,
   input  logic                  compl_mode,
   output logic                  busy,
   output logic                  done,
   output logic                  empty
);

   if (N_STATES < 2 || N_STATES > 32) begin : g_bad_states
      $error("dfa_empty_chk: N_STATES must lie in 2..32");
   end
   if (IDX_W != $clog2(N_STATES)) begin : g_bad_idx
      $error("dfa_empty_chk: IDX_W must equal clog2(N_STATES)");
   end
   if (SUCC_IMPL != 0 && SUCC_IMPL != 1) begin : g_bad_impl
      $error("dfa_empty_chk: SUCC_IMPL must be 0 or 1");
   end

   logic [N_STATES-1:0][IDX_W-1:0] nxt0;
   logic [N_STATES-1:0][IDX_W-1:0] nxt1;
   logic [IDX_W-1:0]               start_idx;
   logic [N_STATES-1:0]            final_mask;
   logic [N_STATES-1:0]            frontier;
   logic [N_STATES-1:0]            succ;
   logic                           lock;

   assign lock = busy || start;

   dfa_table #(.N_STATES(N_STATES), .IDX_W(IDX_W)) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_sel     (wr_sel),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .lock       (lock),
      .nxt0       (nxt0),
      .nxt1       (nxt1),
      .start_idx  (start_idx),
      .final_mask (final_mask)
   );

   dfa_succ #(.N_STATES(N_STATES), .IDX_W(IDX_W), .SUCC_IMPL(SUCC_IMPL)) u_succ (
      .frontier (frontier),
      .nxt0     (nxt0),
      .nxt1     (nxt1),
      .succ     (succ)
   );

   dfa_search #(.N_STATES(N_STATES), .IDX_W(IDX_W)) u_search (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .compl_mode (compl_mode),
      .start_idx  (start_idx),
      .final_mask (final_mask),
      .succ       (succ),
      .frontier   (frontier),
      .busy       (busy),
      .done       (done),
      .empty      (empty)
   );

endmodule

// File: tb/dfa_empty_chk_bench.sv
module dfa_empty_chk_bench;

   localparam int N  = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = 2'b00;
   logic [IW-1:0] wr_addr = '0;
   logic [N-1:0]  wr_data = '0;
   logic          start = 1'b0;
   logic          compl_mode = 1'b0;
   logic          busy, done, empty;

   int checks = 0;
   int errors = 0;

   int m_n0 [N];
   int m_n1 [N];
   int m_start;
   int m_final;

   always #2.5 clk = ~clk;

   dfa_empty_chk #(.N_STATES(N)) u_dfa_empty_chk (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_addr(wr_addr), .wr_data(wr_data), .start(start),
      .compl_mode(compl_mode), .busy(busy), .done(done), .empty(empty)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic wr(input int sel, input int addr, input int data, input bit track);
      wr_en = 1'b1; wr_sel = 2'(sel); wr_addr = IW'(addr); wr_data = N'(data);
      @(negedge clk);
      wr_en = 1'b0;
      if (track) begin
         if (sel == 0) m_n0[addr] = data % N;
         if (sel == 1) m_n1[addr] = data % N;
         if (sel == 2) m_start = data % N;
         if (sel == 3) m_final = data & 8'hFF;
      end
   endtask

   // Behavioural level-by-level model: queue of states per level.
   task automatic model(input bit cm, output int cycles, output bit emp, output bit zero_mask);
      bit seen [N];
      int level [$];
      int nxt [$];
      int acc;
      acc = cm ? (~m_final & 8'hFF) : m_final;
      zero_mask = (acc == 0);
      foreach (seen[i]) seen[i] = 1'b0;
      level.push_back(m_start);
      seen[m_start] = 1'b1;
      cycles = 0;
      forever begin
         bit hit;
         cycles++;
         hit = 1'b0;
         foreach (level[i]) if (acc[level[i]]) hit = 1'b1;
         if (hit) begin emp = 1'b0; return; end
         if (level.size() == 0) begin emp = 1'b1; return; end
         nxt.delete();
         foreach (level[i]) begin
            int a = m_n0[level[i]];
            int b = m_n1[level[i]];
            if (!seen[a]) begin seen[a] = 1'b1; nxt.push_back(a); end
            if (!seen[b]) begin seen[b] = 1'b1; nxt.push_back(b); end
         end
         level = nxt;
      end
   endtask

   // mode 0: plain run; 1: attempt a write at step 1; 2: extra start at step 1
   task automatic run(input bit cm, input string tag, input int mode);
      int  cyc;
      bit  emp, zm;
      string etag;
      model(cm, cyc, emp, zm);
      etag = zm ? "R6" : (cm ? "R7" : (emp ? "R5" : "R4"));
      compl_mode = cm;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      compl_mode = 1'b0;
      for (int k = 0; k <= cyc; k++) begin
         chk(tag, "busy", int'(busy), int'(k < cyc));
         chk(tag, "done", int'(done), int'(k >= cyc));
         if (k >= cyc) chk(etag, "empty", int'(empty), int'(emp));
         if (k == 1 && k < cyc && mode == 1) begin
            wr_en = 1'b1; wr_sel = 2'b11; wr_data = ~N'(m_final);
         end else if (k == 1 && k < cyc && mode == 2) begin
            start = 1'b1; compl_mode = ~cm;
         end
         @(negedge clk);
         wr_en = 1'b0; start = 1'b0; compl_mode = 1'b0;
      end
      chk("R8", "done held", int'(done), 1);
      chk("R8", "empty held", int'(empty), int'(emp));
      chk("R9", "cycle bound", int'(cyc <= N + 1), 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < N; i++) begin m_n0[i] = i; m_n1[i] = i; end
      m_start = 0; m_final = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "busy", int'(busy), 0);
      chk("R1", "done", int'(done), 0);
      chk("R1", "empty", int'(empty), 0);
      run(1'b0, "R1", 0);                       // reset table: self loops, mask 0

      // chain 0->1->..->7, accepting state 7 only: deepest reach (R3, R4)
      for (int s = 0; s < N; s++) wr(0, s, (s < N - 1) ? s + 1 : s, 1'b1);
      wr(3, 0, 8'h80, 1'b1);
      run(1'b0, "R3", 0);
      run(1'b1, "R7", 0);                        // complement: start 0 now accepting
      // start state accepting
      wr(2, 0, 7, 1'b1);
      run(1'b0, "R3", 0);
      // unreachable accepting state
      wr(2, 0, 3, 1'b1);
      wr(3, 0, 8'h01, 1'b1);
      run(1'b0, "R5", 0);
      // write dropped while busy, and same-cycle as start
      wr(2, 0, 0, 1'b1);
      wr(3, 0, 8'h80, 1'b1);
      run(1'b0, "R2", 1);
      run(1'b0, "R2", 0);                        // mask unchanged by blocked write
      wr_en = 1'b1; wr_sel = 2'b11; wr_data = 8'h00; start = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; start = 1'b0;
      while (busy) @(negedge clk);
      run(1'b0, "R2", 0);                        // still 8'h80
      // restart ignored while busy
      run(1'b0, "R8", 2);
      // input-1 edges
      for (int s = 0; s < N; s++) wr(0, s, s, 1'b1);
      wr(1, 0, 5, 1'b1); wr(1, 5, 2, 1'b1);
      wr(3, 0, 8'h04, 1'b1);
      run(1'b0, "R2", 0);
      wr(3, 0, 8'h00, 1'b1);
      run(1'b0, "R6", 0);
      wr(3, 0, 8'hFF, 1'b1);
      run(1'b1, "R6", 0);                        // complement of full mask is zero

      for (int t = 0; t < 60; t++) begin
         for (int s = 0; s < N; s++) begin
            wr(0, s, int'($urandom_range(0, N - 1)), 1'b1);
            wr(1, s, int'($urandom_range(0, N - 1)), 1'b1);
         end
         wr(2, 0, int'($urandom_range(0, N - 1)), 1'b1);
         if (t % 4 == 0) wr(3, 0, 0, 1'b1);
         else            wr(3, 0, int'(N'(1) << $urandom_range(0, N - 1)), 1'b1);
         run(t[0], "R3", 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule